// File: doc/BRIEF.md
# Cascadable Synchronous Binary Counter

This block is a small binary up-counter, four bits wide by default. All of its state bits update together on the rising clock edge. On an edge it can clear, load a parallel word, count up by one or hold. Two enables must both be high for it to count. The first, the group enable, is shared by all stages. The second, the chain enable, also gates the terminal-count output. Wider counters are built by feeding each stage's terminal count into the next stage's chain enable. The group enable and the clock are shared by all stages.

A build-time parameter sets how the active-low clear input works. With `CLR_SYNC` (the default) the clear takes effect at the next rising edge. With `CLR_ASYNC` it forces the count to zero at once. In synchronous mode, the clear can be driven from a decode of the outputs. The counter then wraps early and runs as a modulo-N counter.

Top module: `casc_bin_counter`

## Requirements
- R1: With `CLR_MODE = CLR_ASYNC`, a low on `clr_n` drives `q` to all zeros immediately, with no clock edge, whatever `load_n`, `din`, `en_par` and `en_trk` are.
- R2: With `CLR_MODE = CLR_SYNC`, a low on `clr_n` clears `q` to zero at the next rising edge, whatever `load_n`, `en_par` and `en_trk` are. `q` does not change between edges.
- R3: With `clr_n` high and `load_n` low, `q` takes the value of `din` on the rising edge, whatever `en_par` and `en_trk` are.
- R4: With `clr_n` and `load_n` high and both `en_par` and `en_trk` high, `q` increases by one on the rising edge, and all ones wraps to zero.
- R5: With `clr_n` and `load_n` high and either enable low, `q` keeps its value across the edge.
- R6: `tc_out` is high exactly when `en_trk` is high and `q` is all ones. It is combinational, and `en_par` has no effect on it.
- R7: On an edge the clear wins over the load, the load wins over the count, and the count wins over the hold.
- R8: When several stages share the clock, `clr_n`, `load_n` and `en_par`, and each stage's `tc_out` drives the next stage's `en_trk`, the chain behaves as one binary counter whose width is the sum of the stage widths. The last `tc_out` is high when the chain's first `en_trk` is high and every stage is all ones.
- R9: In synchronous mode, driving `clr_n` low while `q` equals 9 gives a counter that steps through 0 to 9 and then returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on its rising edge |
| clr_n | input | 1 | Active-low clear, synchronous or asynchronous according to `CLR_MODE` |
| load_n | input | 1 | Active-low parallel load of `din` |
| din | input | WIDTH | Parallel load data |
| en_par | input | 1 | Group count enable, shared across a chain |
| en_trk | input | 1 | Chain count enable; also gates `tc_out` |
| q | output | WIDTH | Current count |
| tc_out | output | 1 | Terminal count: `en_trk` high and `q` all ones |

## Verification
A wrong value in the count register shows on `q` at the first sample after the edge that wrote it. From then on every later increment in the model disagrees with it, so the error stays visible until the next clear or load. A fault in the chain decode shows only when `q` reaches all ones. It then appears on `tc_out` at once. In a chain it also appears one edge later as a missed or extra carry in the next stage. The async clear is sampled in the middle of a clock cycle to tell the async and sync clear modes apart.

// File: rtl/cnt_pkg.sv
// Package: shared types for the cascadable counter.
// Assumes: nothing beyond IEEE 1800-2017.
package cnt_pkg;

    // How the active-low clear input acts on the state register.
    typedef enum logic {
        CLR_SYNC  = 1'b0,
        CLR_ASYNC = 1'b1
    } clr_mode_e;

endpackage

// File: rtl/cnt_next.sv
// Module: next-state selection for load, increment and hold.
// Assumes: the clear is applied downstream in the state register,
// so this path only orders load above count above hold.
module cnt_next #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             load_n,
    input  logic [WIDTH-1:0] din,
    input  logic             en_par,
    input  logic             en_trk,
    output logic [WIDTH-1:0] nxt
);

    logic run;

    // Both enables are needed for a count step.
    assign run = en_par & en_trk;

    // Pick the value for the next edge: load, then count, else hold.
    always_comb begin
        if (!load_n) begin
            nxt = din;
        end else if (run) begin
            nxt = cur + {{(WIDTH-1){1'b0}}, 1'b1};
        end else begin
            nxt = cur;
        end
    end

endmodule

// File: rtl/cnt_state_reg.sv
// Module: count state register with the clear style chosen at build time.
// Assumes: clr_n is active low. In async mode it is a true
// asynchronous clear; in sync mode it acts only on the rising edge.
module cnt_state_reg
    import cnt_pkg::*;
#(
    parameter int        WIDTH    = 4,
    parameter clr_mode_e CLR_MODE = CLR_SYNC
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [WIDTH-1:0] nxt,
    output logic [WIDTH-1:0] q
);

    generate
        if (CLR_MODE == CLR_ASYNC) begin : g_async
            // Asynchronous clear; otherwise capture the next value.
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n) begin
                    q <= '0;
                end else begin
                    q <= nxt;
                end
            end
        end else begin : g_sync
            // Clear on the edge, ahead of every other action.
            always_ff @(posedge clk) begin
                if (!clr_n) begin
                    q <= '0;
                end else begin
                    q <= nxt;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/cnt_tc_decode.sv
// Module: terminal-count decode, gated by the chain enable.
// Assumes: purely combinational; the group enable does not enter.
module cnt_tc_decode #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] q,
    input  logic             en_trk,
    output logic             tc
);

    logic [WIDTH:0] chain;

    // The chain enable seeds an AND chain across the state bits.
    assign chain[0] = en_trk;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_and
            assign chain[i+1] = chain[i] & q[i];
        end
    endgenerate

    assign tc = chain[WIDTH];

endmodule

// File: rtl/casc_bin_counter.sv
// Module: one cascadable stage of a synchronous binary up-counter.
// Assumes: all stages of a chain share clk, clr_n, load_n and en_par;
// tc_out of one stage feeds en_trk of the next.
module casc_bin_counter
    import cnt_pkg::*;
#(
    parameter int        WIDTH    = 4,
    parameter clr_mode_e CLR_MODE = CLR_SYNC
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             load_n,
    input  logic [WIDTH-1:0] din,
    input  logic             en_par,
    input  logic             en_trk,
    output logic [WIDTH-1:0] q,
    output logic             tc_out
);

    logic [WIDTH-1:0] nxt;

    // Next value from load, count or hold.
    cnt_next #(.WIDTH(WIDTH)) u_next (
        .cur    (q),
        .load_n (load_n),
        .din    (din),
        .en_par (en_par),
        .en_trk (en_trk),
        .nxt    (nxt)
    );

    // State register with the selected clear style.
    cnt_state_reg #(.WIDTH(WIDTH), .CLR_MODE(CLR_MODE)) u_reg (
        .clk   (clk),
        .clr_n (clr_n),
        .nxt   (nxt),
        .q     (q)
    );

    // Terminal count for the next stage.
    cnt_tc_decode #(.WIDTH(WIDTH)) u_tc (
        .q      (q),
        .en_trk (en_trk),
        .tc     (tc_out)
    );

endmodule

// File: rtl/cnt_chk.sv
// Module: property checker for casc_bin_counter, attached by bind.
// Assumes: the checks are armed after the first rising edge.
module cnt_chk
    import cnt_pkg::*;
#(
    parameter int        WIDTH    = 4,
    parameter clr_mode_e CLR_MODE = CLR_SYNC
) (
    input logic             clk,
    input logic             clr_n,
    input logic             load_n,
    input logic [WIDTH-1:0] din,
    input logic             en_par,
    input logic             en_trk,
    input logic [WIDTH-1:0] q,
    input logic             tc_out
);

    localparam bit IS_ASYNC = (CLR_MODE == CLR_ASYNC);

    logic armed = 1'b0;

    // Arm the checks once one edge has passed.
    always_ff @(posedge clk) begin
        armed <= 1'b1;
    end

    // R1
    async_clear_chk: assert property (@(posedge clk) disable iff (!armed)
        (IS_ASYNC && !clr_n) |-> (q == '0));

    // R2
    sync_clear_chk: assert property (@(posedge clk) disable iff (!armed)
        (!IS_ASYNC && !clr_n) |=> (q == '0));

    // R3
    load_chk: assert property (@(posedge clk)
        disable iff (!armed || (IS_ASYNC && !clr_n))
        (clr_n && !load_n) |=> (q == $past(din)));

    // R4
    count_step_chk: assert property (@(posedge clk)
        disable iff (!armed || (IS_ASYNC && !clr_n))
        (clr_n && load_n && en_par && en_trk) |=> (q == $past(q) + 1'b1));

    // R5
    hold_chk: assert property (@(posedge clk)
        disable iff (!armed || (IS_ASYNC && !clr_n))
        (clr_n && load_n && !(en_par && en_trk)) |=> $stable(q));

    // R6
    tc_gate_chk: assert property (@(posedge clk) disable iff (!armed)
        !en_trk |-> !tc_out);

    // R6
    tc_full_chk: assert property (@(posedge clk) disable iff (!armed)
        tc_out |-> (&q));

endmodule

bind casc_bin_counter cnt_chk #(.WIDTH(WIDTH), .CLR_MODE(CLR_MODE)) u_chk (
    .clk    (clk),
    .clr_n  (clr_n),
    .load_n (load_n),
    .din    (din),
    .en_par (en_par),
    .en_trk (en_trk),
    .q      (q),
    .tc_out (tc_out)
);

// File: tb/test_casc_bin_counter.sv
// Bench: sync stage, async stage and a three-stage chain, each compared
// against a model computed from the requirements.
module test_casc_bin_counter;
    import cnt_pkg::*;

    localparam int STG = 3;
    localparam int CW  = 4 * STG;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       clr_n = 1'b0, load_n = 1'b1, en_par = 1'b0, en_trk = 1'b0;
    logic [3:0] din = '0;
    logic [3:0] q_s, q_a;
    logic       tc_s, tc_a;

    logic          c_clr_n = 1'b0, c_load_n = 1'b1, c_ep = 1'b0, c_et = 1'b0;
    logic [CW-1:0] c_din = '0;
    wire  [CW-1:0] c_q;
    wire  [STG:0]  c_chain;

    int  n_chk = 0, n_err = 0;
    bit  done  = 1'b0;
    logic [11:0] m_s = '0, m_a = '0, m_c = '0;
    string tag_s, tag_a;

    casc_bin_counter i_casc_bin_counter (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din),
        .en_par(en_par), .en_trk(en_trk), .q(q_s), .tc_out(tc_s));

    casc_bin_counter #(.CLR_MODE(CLR_ASYNC)) i_async (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din),
        .en_par(en_par), .en_trk(en_trk), .q(q_a), .tc_out(tc_a));

    assign c_chain[0] = c_et;
    for (genvar k = 0; k < STG; k++) begin : g_stg
        casc_bin_counter u_stg (
            .clk(clk), .clr_n(c_clr_n), .load_n(c_load_n), .din(c_din[4*k +: 4]),
            .en_par(c_ep), .en_trk(c_chain[k]), .q(c_q[4*k +: 4]),
            .tc_out(c_chain[k+1]));
    end

    function automatic logic [11:0] model(input logic [11:0] cur, input logic clr,
            input logic ld, input logic [11:0] d, input logic ep, input logic et,
            input int w);
        logic [11:0] mask = (12'(1) << w) - 12'(1);
        if (!clr)          return '0;
        if (!ld)           return d & mask;
        if (ep && et)      return (cur + 12'(1)) & mask;
        return cur;
    endfunction

    function automatic string which(input logic clr, input logic ld,
            input logic ep, input logic et, input string clr_tag);
        if (!clr)     return clr_tag;
        if (!ld)      return (ep && et) ? "R7" : "R3";
        if (ep && et) return "R4";
        return "R5";
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One edge: update models at the edge, compare at the next falling edge.
    task automatic cycle();
        @(posedge clk);
        tag_s = which(clr_n, load_n, en_par, en_trk, "R2");
        tag_a = which(clr_n, load_n, en_par, en_trk, "R1");
        m_s = model(m_s, clr_n, load_n, {8'h0, din}, en_par, en_trk, 4);
        m_a = model(m_a, clr_n, load_n, {8'h0, din}, en_par, en_trk, 4);
        m_c = model(m_c, c_clr_n, c_load_n, c_din, c_ep, c_et, CW);
        @(negedge clk);
        check(tag_s, 32'(q_s), 32'(m_s));
        check(tag_a, 32'(q_a), 32'(m_a));
        check("R6", 32'(tc_s), 32'(en_trk && m_s == 12'hf));
        check("R6", 32'(tc_a), 32'(en_trk && m_a == 12'hf));
        check("R8", 32'(c_q), 32'(m_c));
        check("R8", 32'(c_chain[STG]), 32'(c_et && m_c == 12'hfff));
    endtask

    task automatic drive(input logic c, input logic l, input logic [3:0] d,
            input logic ep, input logic et);
        clr_n = c; load_n = l; din = d; en_par = ep; en_trk = et;
    endtask

    initial begin
        int mod_exp;
        void'($urandom(32'd1234));
        // Reset state: clear on the first edge everywhere.
        drive(1'b0, 1'b0, 4'h9, 1'b1, 1'b1);
        cycle();
        c_clr_n = 1'b1;
        // R3: load 5 with enables low.
        drive(1'b1, 1'b0, 4'h5, 1'b0, 1'b0);
        cycle();
        // R1 vs R2: mid-cycle clear drop.
        drive(1'b0, 1'b1, 4'h0, 1'b1, 1'b1);
        #1;
        check("R1", 32'(q_a), 32'h0);
        check("R2", 32'(q_s), 32'h5);
        m_a = '0;
        cycle();
        // R3 / R6: load all ones, chain enable high, group enable low.
        drive(1'b1, 1'b0, 4'hf, 1'b0, 1'b1);
        cycle();
        drive(1'b1, 1'b1, 4'h0, 1'b0, 1'b1);
        #1;
        check("R6", 32'(tc_s), 32'h1);
        en_trk = 1'b0;
        #1;
        check("R6", 32'(tc_s), 32'h0);
        cycle();
        // R4: wrap from all ones to zero.
        drive(1'b1, 1'b1, 4'h3, 1'b1, 1'b1);
        cycle();
        check("R4", 32'(q_s), 32'h0);
        // R7: clear beats load, load beats count.
        drive(1'b1, 1'b0, 4'ha, 1'b1, 1'b1);
        cycle();
        check("R7", 32'(q_s), 32'ha);
        drive(1'b0, 1'b0, 4'h6, 1'b1, 1'b1);
        cycle();
        check("R7", 32'(q_s), 32'h0);
        // Random mix on the single stages.
        for (int i = 0; i < 400; i++) begin
            drive(($urandom % 16) != 0, ($urandom % 8) != 0, 4'($urandom),
                  ($urandom % 4) != 0, ($urandom % 4) != 0);
            cycle();
        end
        // R8: chain carry across stage borders.
        drive(1'b1, 1'b1, 4'h0, 1'b0, 1'b0);
        c_load_n = 1'b0; c_din = 12'h0ff; c_ep = 1'b1; c_et = 1'b1;
        cycle();
        c_load_n = 1'b1;
        cycle();
        check("R8", 32'(c_q), 32'h100);
        c_load_n = 1'b0; c_din = 12'hffd;
        cycle();
        c_load_n = 1'b1;
        for (int i = 0; i < 300; i++) begin
            c_ep = ($urandom % 4) != 0;
            c_et = ($urandom % 5) != 0;
            c_load_n = ($urandom % 50) != 0;
            c_din = 12'($urandom);
            cycle();
        end
        // R9: modulo-10 through a decoded synchronous clear.
        c_load_n = 1'b1;
        drive(1'b0, 1'b1, 4'h0, 1'b1, 1'b1);
        cycle();
        mod_exp = 0;
        for (int i = 0; i < 30; i++) begin
            drive(q_s != 4'd9, 1'b1, 4'h0, 1'b1, 1'b1);
            cycle();
            mod_exp = (mod_exp + 1) % 10;
            check("R9", 32'(q_s), 32'(mod_exp));
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule